// File: doc/BRIEF.md
# Split-Interval Modulus Divider

This block divides a fast oscillator clock by an integer modulus between 96 and 159. A single short down-counter is reused several times in each division interval. One or more fixed-length segments come first, and one variable-length tail segment closes the interval. Because the tail length is only needed near the end of the fixed part, the modulus may be supplied well after the interval has started. That suits a loop which computes the next modulus while the current division is already running. The block is modelled with synchronous counters and a small state machine.

The sequencer has three states. LONG counts one 80-cycle segment. SHORT counts 32-cycle segments and keeps a repeat index. TAIL counts the variable remainder. The transitions are:

- LONG_DONE: LONG goes to TAIL.
- SHORT_NEXT: SHORT stays in SHORT and advances the repeat index.
- SHORT_DONE: SHORT goes to TAIL after the third segment.
- WRAP_LONG: TAIL goes to LONG.
- WRAP_SHORT: TAIL goes to SHORT.

WRAP_LONG and WRAP_SHORT start the next interval. The choice between them depends on the band of the modulus held at that moment. A load strobe writes a new modulus word into a holding register. That word is also seen directly in the strobe cycle. A free-running divide-by-8 tap gives a slow system clock.

Top module: `split_mod_divider`

## Requirements
- R1: Throughout reset, `div_pulse` and `slow_clk` are low, and the held modulus is 96. Without any strobe, the first interval after reset is 96 cycles long. Cycle index 0 is the first cycle after reset is released, or the first cycle after a pulse.
- R2: `mod_in` is an unsigned binary value. Strobing any value from 96 to 159 at interval cycle 95 makes the next interval exactly that many cycles long, measured from pulse to pulse.
- R3: `div_pulse` is high for exactly one cycle, the last cycle of each interval. It is never high in two consecutive cycles.
- R4: The band is picked at interval start from the held value. Moduli 96..133 run one 80-cycle segment and then a tail of M-80 cycles. Moduli 134..159 run three 32-cycle segments and then a tail of M-96 cycles. A value captured later that lies in the other band is clamped into the running band, which gives an interval of 133 or 134 cycles.
- R5: A strobed value below 96 acts as 96, and a value above 159 acts as 159.
- R6: In the 80-cycle band, a strobe at interval cycle 72 or earlier sets the tail of the current interval. This leaves at least 8 fixed cycles, counting the strobe cycle. A strobe at cycle 73 or later applies only to the next interval.
- R7: In the three-by-32 band, the deadline for changing the current tail is cycle 88. A strobe at cycle 89 or later applies only to the next interval.
- R8: `slow_clk` has a period of 8 clock cycles. In cycle k after reset it equals bit 2 of k.
- R9: While `mod_load` stays low, every interval repeats the held modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_in | input | 8 | Requested modulus, unsigned |
| mod_load | input | 1 | Strobe that writes `mod_in` into the holding register |
| div_pulse | output | 1 | One-cycle pulse in the last cycle of each interval |
| slow_clk | output | 1 | Divide-by-8 slow clock tap |

## Verification
The bench builds the block with its default parameters: an 8-bit modulus word, an 80-cycle long segment, three 32-cycle short segments, an 8-cycle capture lead and a six-stage tail counter. With these values every legal modulus from 96 to 159 can be swept interval by interval, and out-of-range values can be tried at both ends. The capture deadline is probed one cycle on each side in both bands, and late values that cross bands are checked against the clamped 133 and 134 cycle results.

// File: rtl/smd_pkg.sv
package smd_pkg;
    typedef enum logic [1:0] {
        SEQ_LONG  = 2'd0,
        SEQ_SHORT = 2'd1,
        SEQ_TAIL  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/smd_band.sv
module smd_band #(
    parameter int MOD_W       = 8,
    parameter int MOD_MIN     = 96,
    parameter int MOD_SPLIT   = 134,
    parameter int MOD_MAX     = 159,
    parameter int LONG_LEN    = 80,
    parameter int SHORT_TOTAL = 96,
    parameter int VAR_W       = 6
) (
    input  logic [MOD_W-1:0] mod_req,
    output logic [MOD_W-1:0] mod_clamped,
    output logic             short_sel,
    output logic [VAR_W-1:0] var_long,
    output logic [VAR_W-1:0] var_short
);
    localparam logic [MOD_W-1:0] MIN_V   = MOD_W'(MOD_MIN);
    localparam logic [MOD_W-1:0] MAX_V   = MOD_W'(MOD_MAX);
    localparam logic [MOD_W-1:0] SPLIT_V = MOD_W'(MOD_SPLIT);
    localparam logic [MOD_W-1:0] LOW_TOP = MOD_W'(MOD_SPLIT - 1);
    localparam logic [MOD_W-1:0] LONG_V  = MOD_W'(LONG_LEN);
    localparam logic [MOD_W-1:0] SHORT_V = MOD_W'(SHORT_TOTAL);

    logic [MOD_W-1:0] low_band;
    logic [MOD_W-1:0] high_band;
    logic [MOD_W-1:0] long_diff;
    logic [MOD_W-1:0] short_diff;

    always_comb begin
        if (mod_req < MIN_V) begin
            mod_clamped = MIN_V;
        end else if (mod_req > MAX_V) begin
            mod_clamped = MAX_V;
        end else begin
            mod_clamped = mod_req;
        end
        short_sel  = (mod_clamped >= SPLIT_V);
        low_band   = short_sel ? LOW_TOP : mod_clamped;
        high_band  = short_sel ? mod_clamped : SPLIT_V;
        long_diff  = low_band - LONG_V;
        short_diff = high_band - SHORT_V;
        var_long   = long_diff[VAR_W-1:0];
        var_short  = short_diff[VAR_W-1:0];
    end
endmodule

// File: rtl/smd_tap.sv
module smd_tap #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tap
);
    logic [STAGES-1:0] q;
    logic [STAGES-1:0] carry;

    assign carry[0] = 1'b1;
    for (genvar i = 1; i < STAGES; i++) begin : g_carry
        assign carry[i] = carry[i-1] & q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q ^ carry;
        end
    end

    assign tap = q[STAGES-1];
endmodule

// File: rtl/smd_seq.sv
module smd_seq
    import smd_pkg::*;
#(
    parameter int LONG_LEN   = 80,
    parameter int SHORT_LEN  = 32,
    parameter int SHORT_REPS = 3,
    parameter int LEAD       = 8,
    parameter int VAR_W      = 6,
    parameter int VAR_RESET  = 16,
    parameter int CW         = 7,
    parameter int RW         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             next_short,
    input  logic [VAR_W-1:0] var_long,
    input  logic [VAR_W-1:0] var_short,
    output seq_state_e       state_q,
    output logic [RW-1:0]    rep_q,
    output logic             div_pulse
);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_LEN - 1);
    localparam logic [CW-1:0] CAP_AT   = CW'(LEAD - 1);
    localparam logic [RW-1:0] LAST_REP = RW'(SHORT_REPS - 1);

    seq_state_e       state_d;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    cnt_d;
    logic [RW-1:0]    rep_d;
    logic [VAR_W-1:0] var_q;
    logic [CW-1:0]    tail_m1;
    logic             last_fixed;
    logic             cap;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_LONG;
            cnt_q   <= LONG_M1;
            rep_q   <= '0;
            var_q   <= VAR_W'(VAR_RESET);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rep_q   <= rep_d;
            if (cap) begin
                var_q <= (state_q == SEQ_LONG) ? var_long : var_short;
            end
        end
    end

    // next-state logic
    always_comb begin
        tail_m1 = CW'(var_q) - CW'(1);
        state_d = state_q;
        cnt_d   = cnt_q - CW'(1);
        rep_d   = rep_q;
        unique case (state_q)
            SEQ_LONG: begin
                if (cnt_q == '0) begin
                    state_d = SEQ_TAIL;
                    cnt_d   = tail_m1;
                end
            end
            SEQ_SHORT: begin
                if (cnt_q == '0) begin
                    if (rep_q == LAST_REP) begin
                        state_d = SEQ_TAIL;
                        cnt_d   = tail_m1;
                    end else begin
                        rep_d = rep_q + RW'(1);
                        cnt_d = SHORT_M1;
                    end
                end
            end
            SEQ_TAIL: begin
                if (cnt_q == '0) begin
                    rep_d = '0;
                    if (next_short) begin
                        state_d = SEQ_SHORT;
                        cnt_d   = SHORT_M1;
                    end else begin
                        state_d = SEQ_LONG;
                        cnt_d   = LONG_M1;
                    end
                end
            end
            default: begin
                state_d = SEQ_LONG;
                cnt_d   = LONG_M1;
                rep_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        last_fixed = (state_q == SEQ_LONG) ||
                     ((state_q == SEQ_SHORT) && (rep_q == LAST_REP));
        cap        = last_fixed && (cnt_q == CAP_AT);
        div_pulse  = (state_q == SEQ_TAIL) && (cnt_q == '0);
    end
endmodule

// File: rtl/split_mod_divider.sv
module split_mod_divider
    import smd_pkg::*;
#(
    parameter int MOD_W      = 8,
    parameter int MOD_MIN    = 96,
    parameter int MOD_SPLIT  = 134,
    parameter int MOD_MAX    = 159,
    parameter int LONG_LEN   = 80,
    parameter int SHORT_LEN  = 32,
    parameter int SHORT_REPS = 3,
    parameter int LEAD       = 8,
    parameter int STAGES     = 6,
    parameter int TAP_STAGE  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MOD_W-1:0] mod_in,
    input  logic             mod_load,
    output logic             div_pulse,
    output logic             slow_clk
);
    localparam int VAR_W       = STAGES;
    localparam int SHORT_TOTAL = SHORT_LEN * SHORT_REPS;
    localparam int SPAN        = (LONG_LEN > (1 << VAR_W)) ? LONG_LEN : (1 << VAR_W);
    localparam int CW          = $clog2(SPAN);
    localparam int RW          = (SHORT_REPS > 1) ? $clog2(SHORT_REPS) : 1;

    logic [MOD_W-1:0] pending_q;
    logic [MOD_W-1:0] mod_req;
    logic [MOD_W-1:0] mod_clamped;
    logic             short_sel;
    logic [VAR_W-1:0] var_long;
    logic [VAR_W-1:0] var_short;
    seq_state_e       seq_state;
    logic [RW-1:0]    seq_rep;

    assign mod_req = mod_load ? mod_in : pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= MOD_W'(MOD_MIN);
        end else if (mod_load) begin
            pending_q <= mod_clamped;
        end
    end

    smd_band #(
        .MOD_W(MOD_W), .MOD_MIN(MOD_MIN), .MOD_SPLIT(MOD_SPLIT),
        .MOD_MAX(MOD_MAX), .LONG_LEN(LONG_LEN),
        .SHORT_TOTAL(SHORT_TOTAL), .VAR_W(VAR_W)
    ) u_band (
        .mod_req(mod_req),
        .mod_clamped(mod_clamped),
        .short_sel(short_sel),
        .var_long(var_long),
        .var_short(var_short)
    );

    smd_seq #(
        .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .SHORT_REPS(SHORT_REPS),
        .LEAD(LEAD), .VAR_W(VAR_W), .VAR_RESET(MOD_MIN - LONG_LEN),
        .CW(CW), .RW(RW)
    ) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .next_short(short_sel),
        .var_long(var_long),
        .var_short(var_short),
        .state_q(seq_state),
        .rep_q(seq_rep),
        .div_pulse(div_pulse)
    );

    smd_tap #(.STAGES(TAP_STAGE)) u_tap (
        .clk(clk),
        .rst_n(rst_n),
        .tap(slow_clk)
    );
endmodule

// File: rtl/smd_chk.sv
module smd_chk
    import smd_pkg::*;
#(
    parameter int MOD_MIN    = 96,
    parameter int MOD_MAX    = 159,
    parameter int SHORT_REPS = 3,
    parameter int RW         = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          div_pulse,
    input logic          slow_clk,
    input seq_state_e    state,
    input logic [RW-1:0] rep
);
    logic [7:0] gap;
    logic       slow_prev;
    logic [3:0] hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap       <= '0;
            slow_prev <= 1'b0;
            hold      <= '0;
        end else begin
            gap       <= div_pulse ? 8'd0 : ((gap == 8'hFF) ? gap : gap + 8'd1);
            slow_prev <= slow_clk;
            hold      <= (slow_clk != slow_prev) ? 4'd0 :
                         ((hold == 4'hF) ? hold : hold + 4'd1);
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R3
    AST_PULSE_IN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (state == SEQ_TAIL)); // R2
    AST_PERIOD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> ((gap >= 8'(MOD_MIN - 1)) && (gap <= 8'(MOD_MAX - 1)))); // R5
    AST_LONG_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) == SEQ_LONG) && (state != SEQ_LONG)) |-> (state == SEQ_TAIL)); // R4
    AST_SHORT_LAST_REP: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) == SEQ_SHORT) && (state == SEQ_TAIL)) |-> ($past(rep) == RW'(SHORT_REPS - 1))); // R4
    AST_SLOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_clk != slow_prev) |-> (hold >= 4'd3)); // R8
    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold <= 4'd4); // R8
endmodule

bind split_mod_divider smd_chk #(
    .MOD_MIN(MOD_MIN), .MOD_MAX(MOD_MAX), .SHORT_REPS(SHORT_REPS), .RW(RW)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .div_pulse(div_pulse),
    .slow_clk(slow_clk),
    .state(seq_state),
    .rep(seq_rep)
);

// File: tb/test_split_mod_divider.sv
module test_split_mod_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_load = 1'b0;
    logic [7:0] mod_in = 8'd0;
    logic       div_pulse;
    logic       slow_clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    split_mod_divider i_split_mod_divider (
        .clk(clk), .rst_n(rst_n), .mod_in(mod_in), .mod_load(mod_load),
        .div_pulse(div_pulse), .slow_clk(slow_clk)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampf(input int v);
        return (v < 96) ? 96 : ((v > 159) ? 159 : v);
    endfunction

    task automatic step(input logic s, input logic [7:0] v, output logic p);
        mod_load = s;
        mod_in   = v;
        #1;
        p = div_pulse;
        if (cyc < 64) check("R8 slow_clk", int'(slow_clk), (cyc >> 2) & 1);
        @(negedge clk);
        mod_load = 1'b0;
        cyc++;
    endtask

    // run one interval, strobing v at interval cycle 'at' (-1: no strobe)
    task automatic interval(input int at, input int v, output int len);
        logic p;
        len = 0;
        for (int k = 0; k < 400; k++) begin
            step(k == at, 8'(v), p);
            if (k == 0) check("R3 pulse in first cycle", int'(p), 0);
            if (p) begin
                len = k + 1;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int len;
        int prev;
        int clamp_set[8];
        clamp_set = '{255, 0, 160, 95, 133, 134, 133, 200};

        repeat (3) @(negedge clk);
        #1;
        check("R1 div_pulse in reset", int'(div_pulse), 0);
        check("R1 slow_clk in reset", int'(slow_clk), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;

        interval(-1, 0, len);
        check("R1 first interval", len, 96);

        // sweep every legal modulus, strobed in the last cycle of a 96+ interval
        prev = 96;
        for (int m = 97; m <= 159; m++) begin
            interval(95, m, len);
            check("R2 sweep length", len, prev);
            prev = m;
        end
        for (int i = 0; i < 8; i++) begin
            interval(95, clamp_set[i], len);
            check("R5 clamp or band change", len, prev);
            prev = clampf(clamp_set[i]);
        end
        interval(95, 100, len);
        check("R5 last clamped value", len, prev);

        // capture deadline in the 80-cycle band
        interval(72, 120, len);
        check("R6 strobe at cycle 72", len, 120);
        interval(73, 100, len);
        check("R6 strobe at cycle 73", len, 120);
        interval(95, 140, len);
        check("R6 late value applies next", len, 100);

        // capture deadline in the three-by-32 band
        interval(88, 150, len);
        check("R7 strobe at cycle 88", len, 150);
        interval(89, 140, len);
        check("R7 strobe at cycle 89", len, 150);
        interval(-1, 0, len);
        check("R9 hold without strobe", len, 140);
        interval(-1, 0, len);
        check("R9 hold repeats", len, 140);

        // late values from the other band are clamped into the running band
        interval(10, 100, len);
        check("R4 short band clamps late low value", len, 134);
        interval(-1, 0, len);
        check("R4 long band next interval", len, 100);
        interval(10, 150, len);
        check("R4 long band clamps late high value", len, 133);
        interval(-1, 0, len);
        check("R4 short band next interval", len, 150);
        interval(-1, 0, len);
        check("R9 hold short band", len, 150);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule